// File: doc/BRIEF.md
# Parallel Port Control Register

This block holds the control byte of a multi-mode parallel port and turns it into pad-level signals. Software writes one byte. Six bits are kept. Four of them set the peripheral handshake lines: the strobe, auto-feed, initialise and select-input lines. One bit sets the direction of the data bus, and one bit enables the acknowledge interrupt. The two top bits are reserved.

A 3-bit port mode input decides how the handshake lines are driven. In mode 000 they act as open-collector lines: each one is pulled low or released. In every other mode they are driven push-pull. The mode also decides whether the direction bit is honoured. In modes 000 and 010 the data drivers stay on whatever that bit holds.

The acknowledge input from the peripheral is synchronised inside the block. When the interrupt is enabled, each rising edge of acknowledge sets a sticky interrupt flag. The flag stays set until the host pulses a clear input.

Top module: `ppt_ctrl_reg`

## Requirements
- R1: While reset is asserted, all four line enables, the data enable, the interrupt and the read data are 0. After reset, every stored bit reads 0.
- R2: A write stores `wr_data[5:0]`, and `rd_data[5:0]` returns them from the next cycle on. `rd_data[7:6]` always reads 0, whatever was written to them.
- R3: The line levels are strobe = NOT bit 0, auto-feed = NOT bit 1, initialise = bit 2 and select-input = NOT bit 3. `ctl_out`/`ctl_oe` index 0..3 are strobe, auto-feed, initialise and select-input.
- R4: In mode 000, each line has `ctl_out` = 0 and `ctl_oe` = 1 exactly when its level is low. Otherwise `ctl_oe` = 0.
- R5: In any mode other than 000, `ctl_out` equals the line level and all four `ctl_oe` are 1.
- R6: In modes 000 and 010, `data_oe` is 1 whatever the value of bit 5.
- R7: In all other modes, `data_oe` is the inverse of bit 5: 1 means the port writes to the peripheral, and 0 means it reads from it.
- R8: With bit 4 set, a rising edge on `ack_in` sets `irq` on the third clock edge after the edge is seen. With bit 4 clear, acknowledge edges leave `irq` at 0.
- R9: `irq` stays set until a cycle with `irq_clr` high clears it. A falling edge, or a level held high, does not set it.
- R10: Pad outputs are registered. They follow a register write or a mode change one clock edge after the edge that captures it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the control byte |
| wr_data | input | 8 | Control byte to write |
| rd_data | output | 8 | Control byte read back, with bits 7:6 at zero |
| port_mode | input | 3 | Port operating mode |
| ack_in | input | 1 | Asynchronous acknowledge from the peripheral |
| irq_clr | input | 1 | Clears the sticky interrupt flag |
| irq | output | 1 | Sticky acknowledge interrupt |
| ctl_out | output | 4 | Line output levels: strobe, auto-feed, initialise, select-input |
| ctl_oe | output | 4 | Line output enables |
| data_oe | output | 1 | Data bus output enable |

## Verification
The bench sweeps all eight modes against all 64 stored values. It computes line levels, enables and data direction arithmetically for each pair. That sweep exposes a swapped inversion on any line: a design with one would assert strobe or select at the wrong level. It also exposes a line that is push-pull in mode 000, which would drive a high onto an open-collector net. A design that honours the direction bit in mode 010 would tri-state the data bus during plain printer transfers, and the sweep catches that too. The interrupt tests check the following:
- a level held high does not re-set the flag after a clear;
- falling edges do not set it;
- edges that arrive while the enable is off do not set it.

A level- or either-edge-sensitive design would fail these.

// File: rtl/ppt_ctrl_pkg.sv
package ppt_ctrl_pkg;
  localparam int REG_W      = 8;
  localparam int STORE_W    = 6;
  localparam int MODE_W     = 3;
  localparam int LINE_N     = 4;
  localparam int SYNC_DEPTH = 2;
  localparam int BIT_DIR    = 5;
  localparam int BIT_IEN    = 4;
  localparam logic [MODE_W-1:0] MODE_OPEN_COLL = 3'b000;
  localparam logic [MODE_W-1:0] MODE_STD_FIFO  = 3'b010;
  // per-line inversion: strobe, auto-feed, select-input inverted; initialise not
  localparam logic [LINE_N-1:0] LINE_INVERT = 4'b1011;
  typedef logic [MODE_W-1:0] mode_t;
endpackage

// File: rtl/ppt_line_drv.sv
module ppt_line_drv #(
  parameter bit INVERT = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic ctl_bit,
  input  logic open_coll,
  output logic pad_out,
  output logic pad_oe
);
  logic level;
  assign level = ctl_bit ^ INVERT;

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_out <= 1'b0;
      pad_oe  <= 1'b0;
    end else if (open_coll) begin
      pad_out <= 1'b0;
      pad_oe  <= ~level;
    end else begin
      pad_out <= level;
      pad_oe  <= 1'b1;
    end
  end
endmodule

// File: rtl/ppt_ack_irq.sv
module ppt_ack_irq #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ack_in,
  input  logic irq_en,
  input  logic irq_clr,
  output logic irq
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;
  logic              rise;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= ack_in;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[STAGES-2:0], ack_in};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= sync_q[STAGES-1];
  end

  assign rise = sync_q[STAGES-1] & ~prev_q;

  always_ff @(posedge clk) begin
    if (rst)                 irq <= 1'b0;
    else if (rise && irq_en) irq <= 1'b1;
    else if (irq_clr)        irq <= 1'b0;
  end
endmodule

// File: rtl/ppt_ctrl_reg.sv
module ppt_ctrl_reg
  import ppt_ctrl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_data,
  output logic [REG_W-1:0]  rd_data,
  input  logic [MODE_W-1:0] port_mode,
  input  logic              ack_in,
  input  logic              irq_clr,
  output logic              irq,
  output logic [LINE_N-1:0] ctl_out,
  output logic [LINE_N-1:0] ctl_oe,
  output logic              data_oe
);
  localparam int RSV_W = REG_W - STORE_W;

  logic [STORE_W-1:0] ctrl_q;
  logic               open_coll;
  logic               dir_forced;

  always_ff @(posedge clk) begin
    if (rst)        ctrl_q <= '0;
    else if (wr_en) ctrl_q <= wr_data[STORE_W-1:0];
  end

  assign rd_data    = {{RSV_W{1'b0}}, ctrl_q};
  assign open_coll  = (port_mode == MODE_OPEN_COLL);
  assign dir_forced = open_coll || (port_mode == MODE_STD_FIFO);

  always_ff @(posedge clk) begin
    if (rst) data_oe <= 1'b0;
    else     data_oe <= dir_forced | ~ctrl_q[BIT_DIR];
  end

  generate
    for (genvar i = 0; i < LINE_N; i++) begin : g_line
      ppt_line_drv #(.INVERT(LINE_INVERT[i])) drv_i (
        .clk      (clk),
        .rst      (rst),
        .ctl_bit  (ctrl_q[i]),
        .open_coll(open_coll),
        .pad_out  (ctl_out[i]),
        .pad_oe   (ctl_oe[i])
      );
    end
  endgenerate

  ppt_ack_irq #(.STAGES(SYNC_DEPTH)) ack_i (
    .clk    (clk),
    .rst    (rst),
    .ack_in (ack_in),
    .irq_en (ctrl_q[BIT_IEN]),
    .irq_clr(irq_clr),
    .irq    (irq)
  );
endmodule

// File: rtl/ppt_ctrl_reg_chk.sv
module ppt_ctrl_reg_chk (
  input logic       clk,
  input logic       rst,
  input logic [7:0] rd_data,
  input logic [2:0] port_mode,
  input logic       irq_clr,
  input logic       irq,
  input logic [3:0] ctl_out,
  input logic [3:0] ctl_oe,
  input logic       data_oe
);
  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (rst)
    rd_data[7:6] == 2'b00); // R2
  AST_OC_NO_HIGH: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(port_mode) == 3'b000) |-> ((ctl_out & ctl_oe) == 4'h0)); // R4
  AST_PP_ALL_ON: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(port_mode) != 3'b000) |-> (ctl_oe == 4'hF)); // R5
  AST_STD_DATA_ON: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(port_mode) == 3'b000 || $past(port_mode) == 3'b010)) |-> data_oe); // R6
  AST_DIR_READ: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(port_mode) != 3'b000 && $past(port_mode) != 3'b010 && $past(rd_data[5]))
      |-> !data_oe); // R7
  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(rd_data[4])); // R8
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (rst)
    (irq && !irq_clr) |=> irq); // R9
endmodule

bind ppt_ctrl_reg ppt_ctrl_reg_chk chk_i (
  .clk      (clk),
  .rst      (rst),
  .rd_data  (rd_data),
  .port_mode(port_mode),
  .irq_clr  (irq_clr),
  .irq      (irq),
  .ctl_out  (ctl_out),
  .ctl_oe   (ctl_oe),
  .data_oe  (data_oe)
);

// File: tb/ppt_ctrl_reg_tb.sv
module ppt_ctrl_reg_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic [2:0] port_mode = '0;
  logic       ack_in = 1'b0;
  logic       irq_clr = 1'b0;
  logic       irq;
  logic [3:0] ctl_out;
  logic [3:0] ctl_oe;
  logic       data_oe;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ppt_ctrl_reg dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .port_mode(port_mode), .ack_in(ack_in), .irq_clr(irq_clr), .irq(irq),
    .ctl_out(ctl_out), .ctl_oe(ctl_oe), .data_oe(data_oe)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic write_reg(input logic [7:0] v);
    wr_data = v;
    wr_en   = 1'b1;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  initial begin
    wait_cyc(3);
    check("R1 ctl_oe in reset", {28'd0, ctl_oe}, 32'd0);
    check("R1 data_oe in reset", {31'd0, data_oe}, 32'd0);
    check("R1 irq in reset", {31'd0, irq}, 32'd0);
    rst = 1'b0;
    wait_cyc(1);
    check("R1 rd_data after reset", {24'd0, rd_data}, 32'd0);

    // R2 reserved bits ignored
    write_reg(8'hFF);
    check("R2 readback of 0xFF", {24'd0, rd_data}, 32'h3F);
    write_reg(8'hC5);
    check("R2 readback of 0xC5", {24'd0, rd_data}, 32'h05);

    // R3..R7, R10 sweep of modes and stored values
    for (int m = 0; m < 8; m++) begin
      for (int v = 0; v < 64; v++) begin
        logic [3:0] lvl;
        logic [3:0] e_out;
        logic [3:0] e_oe;
        logic       e_doe;
        port_mode = m[2:0];
        write_reg({2'b10, v[5:0]});
        check("R2 sweep readback", {24'd0, rd_data}, {26'd0, v[5:0]});
        wait_cyc(1);
        lvl = {~v[3], v[2], ~v[1], ~v[0]};
        if (m == 0) begin
          e_out = 4'h0;
          e_oe  = ~lvl;
        end else begin
          e_out = lvl;
          e_oe  = 4'hF;
        end
        e_doe = (m == 0 || m == 2) ? 1'b1 : ~v[5];
        check((m == 0) ? "R4 R3 lines out" : "R5 R3 lines out", {28'd0, ctl_out}, {28'd0, e_out});
        check((m == 0) ? "R4 R3 lines oe" : "R5 R3 lines oe", {28'd0, ctl_oe}, {28'd0, e_oe});
        check((m == 0 || m == 2) ? "R6 data_oe" : "R7 data_oe", {31'd0, data_oe}, {31'd0, e_doe});
      end
    end

    // R10 mode change latency: mode 011 with dir bit set, then mode 010
    port_mode = 3'b011;
    write_reg(8'h20);
    wait_cyc(1);
    check("R7 data_oe read dir", {31'd0, data_oe}, 32'd0);
    port_mode = 3'b010;
    wait_cyc(1);
    check("R10 data_oe after one edge", {31'd0, data_oe}, 32'd1);

    // R8 interrupt enabled
    port_mode = 3'b001;
    write_reg(8'h10);
    wait_cyc(2);
    check("R8 irq idle", {31'd0, irq}, 32'd0);
    ack_in = 1'b1;
    wait_cyc(2);
    check("R8 irq not before 3rd edge", {31'd0, irq}, 32'd0);
    wait_cyc(1);
    check("R8 irq on 3rd edge", {31'd0, irq}, 32'd1);
    wait_cyc(5);
    check("R9 irq sticky", {31'd0, irq}, 32'd1);
    irq_clr = 1'b1;
    wait_cyc(1);
    irq_clr = 1'b0;
    wait_cyc(4);
    check("R9 clear with ack held high", {31'd0, irq}, 32'd0);
    ack_in = 1'b0;
    wait_cyc(5);
    check("R9 falling edge no irq", {31'd0, irq}, 32'd0);

    // R8 disabled
    write_reg(8'h00);
    ack_in = 1'b1;
    wait_cyc(5);
    check("R8 disabled edge no irq", {31'd0, irq}, 32'd0);
    ack_in = 1'b0;
    wait_cyc(3);
    write_reg(8'h10);
    wait_cyc(4);
    check("R8 enable after edge no irq", {31'd0, irq}, 32'd0);
    ack_in = 1'b1;
    wait_cyc(4);
    check("R8 second edge sets irq", {31'd0, irq}, 32'd1);

    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 100000; c++) begin
      @(negedge clk);
      if (done) break;
    end
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=done");
    end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule